// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask and Routing Controller

This block collects fifteen level-sensitive device interrupt lines and one profiling-timer line per processor. It gates them with a system mask and turns them into a 4-bit interrupt level for each of up to four processors. Software changes the mask only through separate write-ones-to-set and write-ones-to-clear addresses, so a routine that handles one source never has to read, modify and write the mask shared with other routines.

Every processor also owns a 16-bit software pending register with its own set and clear addresses. Any processor may write into another processor's register, so the same mechanism serves as the inter-processor interrupt path. All unmasked device interrupts go to a single target processor chosen by software. Each processor's output is the highest level requested among the sources that reach it.

Top module: `intc_mp_irq_ctrl`

## Requirements
- R1: A write to word address 1 sets (masks) each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R2: A write to word address 2 clears (unmasks) each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: Processor c has a soft pending register with a set address at 8+2c and a clear address at 9+2c. Both use write-ones semantics. A set soft bit k (k = 1..15) requests level k on that processor only. Bit 0 is stored but requests no level.
- R4: The target register at word address 3 resets to 0. Unmasked device requests reach only the processor it names.
- R5: Device input bit i maps to a level, and mask bit i gates it. Bits 0..6 map to levels 2,3,5,7,9,11,13. Bits 7..10 map to levels 4,6,8,10. Bit 11 maps to 11, bits 12 and 13 map to 12, and bit 14 maps to 13.
- R6: Mask bit 15 gates every processor's profiling-timer input, which requests level 14 on its own processor. Mask bit 31 blocks all device and timer requests. After reset the mask reads 0xFFFFFFFF.
- R7: Each 4-bit output field, at bits [4c+3:4c], holds the highest level requested for that processor, or 0 when nothing is requested.
- R8: Reads are combinational and have no side effects. Address 0 returns the raw device inputs. Addresses 1 and 2 return the mask. Address 3 returns the target. Addresses 8+2c and 9+2c return processor c's soft register. Any other address returns 0.
- R9: Device and timer inputs are level-sensitive. A request disappears as soon as its input drops, and nothing is latched.
- R10: Writes to address 0, and cycles with the write strobe low, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| dev_src_i | input | 15 | Device interrupt lines |
| prof_tick_i | input | 4 | Per-processor profiling timer lines |
| irq_level_o | output | 16 | Per-processor level, 4 bits each |

## Verification
A vector table opens the mask piece by piece. It first shows that clearing the mask-all bit alone releases nothing. Then a low-level and a high-level device source are raised together, which tells priority selection apart from simple OR-ing. Moving the target shows that device levels follow the target register. Soft bits are set on one processor, which shows that the other processors' fields stay put. Setting and then clearing a level-15 soft bit shows both the override and the withdrawal of an inter-processor request. Directed steps then drive the shared levels 11 and 12 from different inputs. They also write to the read-only address and with the strobe low, and read back the registers. A final mid-run reset checks that every register returns to its reset value.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DEV_N    = 15;
  localparam int DATA_W   = 32;
  localparam int LVL_W    = 4;
  localparam int LVL_N    = 1 << LVL_W;
  localparam int PROF_BIT = 15;
  localparam int ALL_BIT  = 31;
  localparam int PROF_LVL = 14;

  // device source index -> processor level
  function automatic logic [LVL_W-1:0] dev_level(input int idx);
    case (idx)
      0: return 4'd2;   1: return 4'd3;   2: return 4'd5;   3: return 4'd7;
      4: return 4'd9;   5: return 4'd11;  6: return 4'd13;  7: return 4'd4;
      8: return 4'd6;   9: return 4'd8;   10: return 4'd10; 11: return 4'd11;
      12: return 4'd12; 13: return 4'd12; 14: return 4'd13;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
  parameter int          W     = 32,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (set_i) q_d = q_d | bits_i;
    if (clr_i) q_d = q_d & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= RST_V;
    else         q_o <= q_d;

  AST_SET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(bits_i)) == $past(bits_i))); // R1
  AST_CLR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q_o & $past(bits_i)) == '0)); // R2
  AST_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) |=> (((q_o ^ $past(q_o)) & ~$past(bits_i)) == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o)); // R10
endmodule

// File: rtl/intc_lvl_enc.sv
module intc_lvl_enc
  import intc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_N-1:0] req_i,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int k = 1; k < LVL_N; k++)
      if (req_i[k]) lvl_o = LVL_W'(k);
  end

  AST_NONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[LVL_N-1:1] == '0) |-> (lvl_o == '0)); // R7
  AST_HIT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o != '0) |-> (req_i[lvl_o] && ((req_i >> lvl_o) == 1))); // R7
endmodule

// File: rtl/intc_mp_irq_ctrl.sv
module intc_mp_irq_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [3:0]               addr_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [DEV_N-1:0]         dev_src_i,
  input  logic [NUM_CPU-1:0]       prof_tick_i,
  output logic [NUM_CPU*LVL_W-1:0] irq_level_o
);
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam logic [3:0] A_RAW = 4'd0, A_MSET = 4'd1, A_MCLR = 4'd2, A_TGT = 4'd3;
  localparam logic [3:0] A_SOFT = 4'd8;

  logic [DATA_W-1:0] mask_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [LVL_N-1:0]  soft_q [NUM_CPU];
  logic [DEV_N-1:0]  dev_pend;
  logic [LVL_N-1:0]  dev_req;
  logic              prof_ok;

  intc_setclr_reg #(.W(DATA_W), .RST_V({DATA_W{1'b1}})) u_mask (
    .clk_i, .rst_ni,
    .set_i (wr_i && addr_i == A_MSET),
    .clr_i (wr_i && addr_i == A_MCLR),
    .bits_i(wdata_i),
    .q_o   (mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     tgt_q <= '0;
    else if (wr_i && addr_i == A_TGT) tgt_q <= wdata_i[TGT_W-1:0];

  assign dev_pend = dev_src_i & ~mask_q[DEV_N-1:0] & {DEV_N{~mask_q[ALL_BIT]}};
  assign prof_ok  = ~mask_q[PROF_BIT] & ~mask_q[ALL_BIT];

  always_comb begin
    dev_req = '0;
    for (int i = 0; i < DEV_N; i++)
      if (dev_pend[i]) dev_req[dev_level(i)] = 1'b1;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [LVL_N-1:0] req;

    intc_setclr_reg #(.W(LVL_N), .RST_V('0)) u_soft (
      .clk_i, .rst_ni,
      .set_i (wr_i && addr_i == A_SOFT + 4'(2*c)),
      .clr_i (wr_i && addr_i == A_SOFT + 4'(2*c+1)),
      .bits_i(wdata_i[LVL_N-1:0]),
      .q_o   (soft_q[c])
    );

    always_comb begin
      req = {soft_q[c][LVL_N-1:1], 1'b0};
      if (tgt_q == TGT_W'(c)) req = req | dev_req;
      if (prof_tick_i[c] && prof_ok) req[PROF_LVL] = 1'b1;
    end

    intc_lvl_enc u_enc (
      .clk_i, .rst_ni,
      .req_i(req),
      .lvl_o(irq_level_o[c*LVL_W +: LVL_W])
    );

    if (c > 0) begin : g_nt
      AST_SOFT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tgt_q != TGT_W'(c) && !prof_tick_i[c] && soft_q[c][LVL_N-1:1] == '0)
        |-> (irq_level_o[c*LVL_W +: LVL_W] == '0)); // R4
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_RAW)                          rdata_o = DATA_W'(dev_src_i);
    else if (addr_i == A_MSET || addr_i == A_MCLR) rdata_o = mask_q;
    else if (addr_i == A_TGT)                     rdata_o = DATA_W'(tgt_q);
    else
      for (int c = 0; c < NUM_CPU; c++)
        if (addr_i[3:1] == 3'(4 + c)) rdata_o = DATA_W'(soft_q[c]);
  end

  logic soft_any;
  always_comb begin
    soft_any = 1'b0;
    for (int c = 0; c < NUM_CPU; c++) soft_any = soft_any | (|soft_q[c][LVL_N-1:1]);
  end

  AST_MASK_ALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q[ALL_BIT] && !soft_any) |-> (irq_level_o == '0)); // R6
  AST_RAW_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_RAW) |=> ($stable(mask_q) && $stable(tgt_q))); // R10
endmodule

// File: tb/intc_mp_irq_ctrl_tb.sv
module intc_mp_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [14:0] src = '0;
  logic [3:0]  prof = '0;
  logic [15:0] lvl;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  intc_mp_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .dev_src_i(src), .prof_tick_i(prof), .irq_level_o(lvl));

  typedef struct packed {
    logic        w;
    logic [3:0]  a;
    logic [31:0] d;
    logic [14:0] s;
    logic [3:0]  p;
    logic [15:0] e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'h2, 32'h8000_0000, 15'h0080, 4'h0, 16'h0000}, // R2 R5: still masked
    '{1'b1, 4'h2, 32'h0000_0080, 15'h0080, 4'h0, 16'h0004}, // R5 bit7 -> 4
    '{1'b1, 4'h2, 32'h0000_007F, 15'h00C0, 4'h0, 16'h000D}, // R7 slot6 13 over 4
    '{1'b1, 4'h1, 32'h0000_0040, 15'h00C0, 4'h0, 16'h0004}, // R1 mask slot6
    '{1'b1, 4'h3, 32'h0000_0002, 15'h0080, 4'h0, 16'h0400}, // R4 target cpu2
    '{1'b1, 4'hA, 32'h0000_0200, 15'h0080, 4'h0, 16'h0490}, // R3 cpu1 soft 9
    '{1'b1, 4'hC, 32'h0000_8000, 15'h0080, 4'h0, 16'h0F90}, // R3 cpu2 soft 15
    '{1'b1, 4'hD, 32'h0000_8000, 15'h0080, 4'h0, 16'h0490}, // R3 withdraw
    '{1'b1, 4'h2, 32'h0000_8000, 15'h0080, 4'h8, 16'hE490}, // R6 profile cpu3
    '{1'b1, 4'h1, 32'h8000_0000, 15'h0080, 4'h8, 16'h0090}, // R6 mask-all
    '{1'b1, 4'h0, 32'hFFFF_FFFF, 15'h0080, 4'h8, 16'h0090}, // R10 raw addr write
    '{1'b0, 4'h2, 32'hFFFF_FFFF, 15'h0080, 4'h8, 16'h0090}, // R10 strobe low
    '{1'b1, 4'hE, 32'h0000_0001, 15'h0080, 4'h8, 16'h0090}  // R3 bit0 no level
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input string req, input logic [31:0] exp);
    @(negedge clk); addr = a; wr = 1'b0;
    #1 check(req, rdata, exp);
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset levels", {16'h0, lvl}, 32'h0);
    rst_n = 1'b1;
    bus_rd(4'h1, "R6 reset mask", 32'hFFFF_FFFF);
    bus_rd(4'h3, "R4 reset target", 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i].a; wdata = VEC[i].d; wr = VEC[i].w; src = VEC[i].s; prof = VEC[i].p;
      @(negedge clk);
      wr = 1'b0;
      #1 check($sformatf("table step %0d R1 R2 R3 R4 R5 R6 R7 R10", i), {16'h0, lvl}, {16'h0, VEC[i].e});
    end

    bus_rd(4'h1, "R1 mask readback", 32'hFFFF_7F40);
    bus_rd(4'h2, "R8 mask via clear addr", 32'hFFFF_7F40);
    bus_rd(4'h3, "R8 target readback", 32'h2);
    bus_rd(4'hB, "R8 cpu1 soft readback", 32'h0000_0200);
    bus_rd(4'hE, "R3 cpu3 soft bit0 stored", 32'h0000_0001);
    bus_rd(4'h0, "R8 raw sources", 32'h0000_0080);
    bus_rd(4'h5, "R8 unmapped address", 32'h0);
    bus_rd(4'h1, "R8 reads no side effect", 32'hFFFF_7F40);

    prof = 4'h0;
    bus_wr(4'h2, 32'h8000_7800);
    @(negedge clk); src = 15'h2000;
    #1 check("R5 kbd bit13 -> 12", {16'h0, lvl}, 32'h0C90);
    @(negedge clk); src = 15'h1000;
    #1 check("R5 serial bit12 -> 12", {16'h0, lvl}, 32'h0C90);
    @(negedge clk); src = 15'h0800;
    #1 check("R5 floppy bit11 -> 11", {16'h0, lvl}, 32'h0B90);
    @(negedge clk); src = 15'h0020;
    #1 check("R5 slot5 -> 11", {16'h0, lvl}, 32'h0B90);
    @(negedge clk); src = 15'h0000;
    #1 check("R9 request drops with input", {16'h0, lvl}, 32'h0090);
    @(negedge clk); src = 15'h0800;
    #1 check("R9 level returns, nothing latched", {16'h0, lvl}, 32'h0B90);

    @(negedge clk); rst_n = 1'b0;
    #1 check("R6 mid-run reset levels", {16'h0, lvl}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    bus_rd(4'h2, "R6 mask after reset", 32'hFFFF_FFFF);
    bus_rd(4'h3, "R4 target after reset", 32'h0);
    bus_rd(4'hB, "R3 soft after reset", 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule